// File: doc/BRIEF.md
# Flash Write Completion Poller

This block runs on the host side of a flash array and waits for a program or erase operation to finish. Software or a sequencer pulses `start` with the address to watch and the byte it expects to find there. For a program that byte is the datum just written. For an erase it is all ones, and the address is any location inside a sector that is being erased. The block then reads that address again and again through a request/acknowledge read port.

On each poll it looks at the status bit, bit 7. While the operation runs, the device returns the complement of the expected bit 7. Once the operation is done, the device returns the true value. When the bit does not yet match, the block looks at the time-limit flag, bit 5. If that flag is set, the block reads once more before it decides, because bit 7 may have flipped in the same read as the flag. The first read that shows the true bit 7 is not trusted for the other seven bits. For that reason, after a match the block makes one extra read and presents that byte as the result.

A poll budget, loaded at start, bounds how long the block waits when the flag never rises. The block finishes with a one-cycle `done` pulse. The `pass` or `fail` result stays until the next accepted start.

Top module: `fpoll_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done`, `pass` and `fail` are 0 and `data_out` is 0.
- R2: A `start` pulse in idle latches `verify_addr`. Every read of that operation presents exactly that address on `rd_addr`.
- R3: When a poll returns bit 7 equal to bit 7 of `expect_data`, the block issues one more read. On its acknowledge it drives `data_out` with that extra byte and pulses `done` with `pass` = 1.
- R4: When a poll's bit 7 differs and bit 5 is 0, the block issues another poll, unless the budget is used up.
- R5: When a poll's bit 7 differs and bit 5 is 1, the block makes exactly one re-check read. If bit 7 of that read matches, it continues as in R3.
- R6: If the re-check read's bit 7 still differs, the block pulses `done` with `fail` = 1 and issues no further read.
- R7: `max_polls` is sampled at start, and a value of 0 is treated as 1. After that many polls with bit 7 differing and bit 5 at 0, the block ends with `fail` and makes no further read.
- R8: `start` has no effect while `busy` is 1. The latched address, the expected byte and the poll budget stay unchanged.
- R9: `done` lasts exactly one cycle. `pass` and `fail` are never both 1, and each stays until the next accepted start, which clears both.
- R10: At most one read is outstanding. `rd_req` stays high with a stable `rd_addr` until the cycle in which `rd_ack` is 1. Each cycle with both `rd_req` and `rd_ack` high completes one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| verify_addr | input | ADDR_W | Address to poll |
| expect_data | input | DATA_W | Expected final byte (all ones for erase) |
| max_polls | input | CNT_W | Poll budget; 0 acts as 1 |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read completion, with data valid |
| rd_data | input | DATA_W | Byte returned by the read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Operation failed or timed out |
| data_out | output | DATA_W | Byte captured after a pass |

## Verification
The bench checks that the reported byte comes from the read after the matching one, not from the matching read itself. A design that skips the capture read would return the stale status byte. It sets bit 5 together with a still-wrong bit 7 and then returns a correct bit 7 on the next read. A design that fails at once on the flag would report `fail` there, and one that ignores the flag would keep polling. It also runs the budget at 0, at an exact fit and at exhaustion. An off-by-one counter shows up as one read too many or too few. Finally, it pulses `start` in the middle of an operation. A design that re-latches would read a different address or stop on the new budget.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_POLL,
      ST_RECHK,
      ST_CAPT
   } fpoll_state_e;

   typedef enum logic [1:0] {
      VD_TRUE,
      VD_RETRY,
      VD_CONFIRM
   } fpoll_verdict_e;

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
   import fpoll_pkg::*;
(
   input  logic           sts_done,
   input  logic           sts_tmo,
   input  logic           exp_done,
   output fpoll_verdict_e verdict
);

   always_comb begin
      if (sts_done == exp_done)
         verdict = VD_TRUE;
      else if (sts_tmo)
         verdict = VD_CONFIRM;
      else
         verdict = VD_RETRY;
   end

endmodule

// File: rtl/fpoll_wdog.sv
module fpoll_wdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] lim_in,
   input  logic             tick,
   output logic             last_poll
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("fpoll_wdog: CNT_W must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= ONE;
      end else if (clr) begin
         cnt_q <= '0;
         lim_q <= (lim_in == '0) ? ONE : lim_in;
      end else if (tick) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign last_poll = ((cnt_q + ONE) == lim_q);

   // R7: the poll count never reaches the budget while a poll can still be issued
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < lim_q);

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
   import fpoll_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int DONE_BIT = 7,
   parameter int TMO_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] verify_addr,
   input  logic [DATA_W-1:0] expect_data,
   input  logic [CNT_W-1:0]  max_polls,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic [DATA_W-1:0] data_out
);

   generate
      if (DONE_BIT >= DATA_W || TMO_BIT >= DATA_W) begin : g_bad_bits
         $error("fpoll_ctrl: status bit positions must lie inside DATA_W");
      end
      if (DONE_BIT == TMO_BIT) begin : g_same_bits
         $error("fpoll_ctrl: DONE_BIT and TMO_BIT must differ");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("fpoll_ctrl: ADDR_W must be at least 1");
      end
   endgenerate

   fpoll_state_e      st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              exp_bit_q;
   fpoll_verdict_e    verdict;
   logic              last_poll;
   logic              accept;
   logic              wd_tick;

   assign accept  = (st_q == ST_IDLE) && start;
   assign wd_tick = (st_q == ST_POLL) && rd_ack && (verdict == VD_RETRY) && !last_poll;

   fpoll_judge u_judge (
      .sts_done (rd_data[DONE_BIT]),
      .sts_tmo  (rd_data[TMO_BIT]),
      .exp_done (exp_bit_q),
      .verdict  (verdict)
   );

   fpoll_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .lim_in    (max_polls),
      .tick      (wd_tick),
      .last_poll (last_poll)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         exp_bit_q <= 1'b0;
         done      <= 1'b0;
         pass      <= 1'b0;
         fail      <= 1'b0;
         data_out  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q    <= verify_addr;
                  exp_bit_q <= expect_data[DONE_BIT];
                  pass      <= 1'b0;
                  fail      <= 1'b0;
                  st_q      <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (rd_ack) begin
                  unique case (verdict)
                     VD_TRUE:    st_q <= ST_CAPT;
                     VD_CONFIRM: st_q <= ST_RECHK;
                     default: begin
                        if (last_poll) begin
                           fail <= 1'b1;
                           done <= 1'b1;
                           st_q <= ST_IDLE;
                        end
                     end
                  endcase
               end
            end
            ST_RECHK: begin
               if (rd_ack) begin
                  if (verdict == VD_TRUE) begin
                     st_q <= ST_CAPT;
                  end else begin
                     fail <= 1'b1;
                     done <= 1'b1;
                     st_q <= ST_IDLE;
                  end
               end
            end
            ST_CAPT: begin
               if (rd_ack) begin
                  data_out <= rd_data;
                  pass     <= 1'b1;
                  done     <= 1'b1;
                  st_q     <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req  = (st_q != ST_IDLE);
   assign busy    = (st_q != ST_IDLE);
   assign rd_addr = addr_q;

   // R10: a pending request is held with a stable address until acknowledged
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: results are mutually exclusive
   a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));

   // R8: the address does not change during an operation
   a_r8_busy_addr: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(rd_addr)));

   // R3: a pass appears only together with the completion pulse
   a_r3_pass_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> done);

   // R6: no read is requested once failure is reported
   a_r6_quiet_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> !rd_req);

endmodule

// File: tb/fpoll_ctrl_tb.sv
module fpoll_ctrl_tb;

   localparam int ADDR_W = 24;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] verify_addr = '0;
   logic [DATA_W-1:0] expect_data = '0;
   logic [CNT_W-1:0]  max_polls = '0;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_ack = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic              busy, done, pass, fail;
   logic [DATA_W-1:0] data_out;

   int checks = 0;
   int errors = 0;

   logic [DATA_W-1:0] resp [0:63];
   int                resp_n = 1;
   int                idx = 0;
   int                lat = 0;
   int                gap = 0;
   int                addr_err = 0;
   logic [ADDR_W-1:0] exp_addr = '0;

   logic              got_pass, got_fail;
   logic [DATA_W-1:0] got_data;
   int                got_reads;

   always #2 clk = ~clk;

   fpoll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .verify_addr(verify_addr),
      .expect_data(expect_data), .max_polls(max_polls), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
      .done(done), .pass(pass), .fail(fail), .data_out(data_out)
   );

   // read responder: acknowledges after lat idle cycles, one read at a time
   initial begin
      forever begin
         @(negedge clk);
         if (rd_ack) begin
            rd_ack = 1'b0;
         end else if (rd_req) begin
            if (gap < lat) begin
               gap++;
            end else begin
               gap = 0;
               rd_ack = 1'b1;
               rd_data = resp[(idx < resp_n) ? idx : resp_n - 1];
               if (rd_addr !== exp_addr) addr_err++;
               idx++;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                         input logic [CNT_W-1:0] lim, input int l);
      bit seen = 0;
      @(negedge clk);
      idx = 0; gap = 0; lat = l; addr_err = 0; exp_addr = a;
      verify_addr = a; expect_data = e; max_polls = lim; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      chk("R9 done seen", 32'(seen), 32'd1);
      got_pass = pass; got_fail = fail; got_data = data_out; got_reads = idx;
      @(negedge clk);
      chk("R9 done one cycle", 32'(done), 32'd0);
      chk("R9 result held", {30'd0, pass, fail}, {30'd0, got_pass, got_fail});
      chk("R2 address", 32'(addr_err), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", {27'd0, busy, rd_req, done, pass, fail}, 32'd0);
      chk("R1 reset data_out", 32'(data_out), 32'd0);
   endtask

   task automatic t_match_first();
      resp[0] = 8'h80; resp[1] = 8'hA5; resp_n = 2;
      run_op(24'h001234, 8'hA5, 16'd10, 0);
      chk("R3 pass", {30'd0, got_pass, got_fail}, 32'd2);
      chk("R3 capture read count", 32'(got_reads), 32'd2);
      chk("R3 data from extra read", 32'(got_data), 32'hA5);
   endtask

   task automatic t_erase_retry();
      resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h88; resp[3] = 8'hFF; resp_n = 4;
      run_op(24'hABCDE0, 8'hFF, 16'd10, 2);
      chk("R4 retry then pass", {30'd0, got_pass, got_fail}, 32'd2);
      chk("R4 read count", 32'(got_reads), 32'd4);
      chk("R4 data", 32'(got_data), 32'hFF);
   endtask

   task automatic t_flag_recover();
      resp[0] = 8'h20; resp[1] = 8'h9F; resp[2] = 8'h81; resp_n = 3;
      run_op(24'h000777, 8'h80, 16'd1, 1);
      chk("R5 recheck pass", {30'd0, got_pass, got_fail}, 32'd2);
      chk("R5 read count", 32'(got_reads), 32'd3);
      chk("R5 data", 32'(got_data), 32'h81);
   endtask

   task automatic t_flag_fail();
      resp[0] = 8'hA0; resp[1] = 8'hA0; resp[2] = 8'h00; resp_n = 3;
      run_op(24'h000042, 8'h00, 16'd10, 0);
      repeat (6) @(negedge clk);
      chk("R6 fail", {30'd0, got_pass, got_fail}, 32'd1);
      chk("R6 no further reads", 32'(idx), 32'd2);
      chk("R6 data_out unchanged", 32'(data_out), 32'h81);
   endtask

   task automatic t_budget();
      resp[0] = 8'h00; resp_n = 1;
      run_op(24'h000100, 8'h80, 16'd3, 1);
      repeat (6) @(negedge clk);
      chk("R7 budget fail", {30'd0, got_pass, got_fail}, 32'd1);
      chk("R7 reads equal budget", 32'(idx), 32'd3);
      run_op(24'h000101, 8'h80, 16'd0, 0);
      repeat (6) @(negedge clk);
      chk("R7 zero budget acts as one", 32'(idx), 32'd1);
      resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80; resp[3] = 8'h9A; resp_n = 4;
      run_op(24'h000102, 8'h80, 16'd3, 0);
      chk("R7 match on last poll passes", {30'd0, got_pass, got_fail}, 32'd2);
      chk("R7 last poll data", 32'(got_data), 32'h9A);
   endtask

   task automatic t_busy_start();
      bit seen = 0;
      resp[0] = 8'h00; resp_n = 1;
      @(negedge clk);
      idx = 0; gap = 0; lat = 2; addr_err = 0; exp_addr = 24'h005555;
      verify_addr = 24'h005555; expect_data = 8'h80; max_polls = 16'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 start clears result", {30'd0, pass, fail}, 32'd0);
      repeat (3) @(negedge clk);
      verify_addr = 24'h00AAAA; expect_data = 8'h00; max_polls = 16'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      chk("R8 done seen", 32'(seen), 32'd1);
      chk("R8 original budget used", 32'(idx), 32'd5);
      chk("R8 original expectation kept", {30'd0, pass, fail}, 32'd1);
      chk("R8 address unchanged", 32'(addr_err), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_handshake();
      int viol = 0;
      resp[0] = 8'h00; resp[1] = 8'h80; resp[2] = 8'h11; resp_n = 3;
      @(negedge clk);
      idx = 0; gap = 0; lat = 4; addr_err = 0; exp_addr = 24'h000900;
      verify_addr = 24'h000900; expect_data = 8'h80; max_polls = 16'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (!rd_ack && gap > 0 && !rd_req) viol++;
         @(negedge clk);
      end
      chk("R10 request held until ack", 32'(viol), 32'd0);
      chk("R10 one read per ack", 32'(idx), 32'd3);
      chk("R10 result", {30'd0, pass, fail, 24'd0, data_out} >> 8 == 0 ? 32'd0 : 32'(data_out), 32'h11);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) resp[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_match_first();
      t_erase_retry();
      t_flag_recover();
      t_flag_fail();
      t_budget();
      t_busy_start();
      t_handshake();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule